// File: doc/BRIEF.md
# Lane Training Substate Interlock Sequencer

This block steps one serial lane through its training substates: two lock phases followed by two ordered-set training phases, ending in a trained state. In each substate it counts the complete ordered sets that the transmitter reports as sent. Separately, it counts consecutive matching symbols received from the far end. It moves on only when both counts have reached their limits.

The two limits are independent and differ in strictness. The receive limit can be met almost at once, so it is latched and held while the transmit count finishes. If the transmit count finishes first, the lane keeps sending the same ordered-set type until the receive side catches up.

Every wait is bounded by a programmable cycle timeout. When the timeout expires, a one-cycle retry pulse is raised and training restarts at the first lock substate. A start request, which arrives when the link enters training from any other state, also restarts training there.

Top module: `lt_interlock_fsm`

## Requirements
- R1: The block leaves a training substate for the next one only when the transmit count has reached its limit and the receive condition is latched. Missing either condition, the substate holds, except for restart or timeout. The advance happens at the clock edge after the cycle in which both conditions are seen.
- R2: In the first lock substate (substate code 1), the receive condition needs two consecutive valid symbols of kind code 1. The transmit condition needs four `tx_set_done` pulses.
- R3: A receive condition met before the transmit count finishes stays latched. The advance then follows the final transmit pulse without any further symbols.
- R4: While the transmit count is met and the receive condition is not, the substate and `send_kind` stay unchanged.
- R5: A valid symbol whose kind differs from the current substate's code sets the consecutive-receive count back to zero. Cycles with `rx_valid` low neither add to nor break the run.
- R6: In a training substate, if no advance has happened by then, the state returns to the first lock substate at edge `timeout_cycles`+1 after entry. `retry` is high for exactly the one cycle after that edge.
- R7: A start request in any state moves the block to substate 1 at the next edge. It clears `trained` and discards all counts and latches.
- R8: The transmit count, the receive run, the receive latch and the timer all start from zero on entry to each substate. Nothing counted earlier carries over.
- R9: The second lock substate (code 2) uses the same limits as the first, 4 transmitted and 2 received. The first training-set substate (code 3) uses `ts_a_tx_thr` and `ts_a_rx_thr`. The second training-set substate (code 4) uses `ts_b_tx_thr` and `ts_b_rx_thr`.
- R10: `trained` rises together with the move to substate 5. This happens one edge after both conditions of substate 4 are seen. It stays high until a start request or reset.
- R11: `send_kind` equals the substate code in substates 1 to 4. It is 0 in idle (code 0) and in the trained state (code 5). The expected receive kind in each training substate equals that same code.
- R12: After reset the block is idle: substate 0, `send_kind` 0, `trained` 0, `retry` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Begin or restart training at substate 1 |
| tx_set_done | input | 1 | One complete ordered set has been transmitted |
| rx_valid | input | 1 | A received symbol is present this cycle |
| rx_kind | input | KIND_W (3) | Kind code of the received symbol |
| timeout_cycles | input | TMO_W (16) | Per-substate wait limit in cycles |
| ts_a_tx_thr | input | CNT_W (8) | Transmit limit, substate 3 |
| ts_a_rx_thr | input | CNT_W (8) | Consecutive-receive limit, substate 3 |
| ts_b_tx_thr | input | CNT_W (8) | Transmit limit, substate 4 |
| ts_b_rx_thr | input | CNT_W (8) | Consecutive-receive limit, substate 4 |
| substate | output | 3 | Current substate code |
| send_kind | output | KIND_W (3) | Ordered-set kind to transmit |
| trained | output | 1 | Training complete |
| retry | output | 1 | One-cycle pulse on timeout restart |

## Verification
The bench pushes receive matches in well before the transmit count completes. A design that failed to latch them would stall there until the timeout. It also completes the transmit count with no matching symbols, where a design that looked at only one condition would advance early. A wrong-kind symbol is placed inside a run to expose a counter that merely pauses, and idle gaps are placed inside a run to expose one that resets too eagerly. Timeouts are driven in both the first and a later substate, and a restart is issued mid-substate. Counts carried over across an entry, or a retry that lasts more than one cycle, would show up as a substate or flag mismatch against the reference model.

// File: rtl/lt_pkg.sv
package lt_pkg;

   typedef enum logic [2:0] {
      LT_IDLE   = 3'd0,
      LT_LOCK_A = 3'd1,
      LT_LOCK_B = 3'd2,
      LT_TSET_A = 3'd3,
      LT_TSET_B = 3'd4,
      LT_DONE   = 3'd5
   } lt_state_e;

   localparam int unsigned LT_KIND_NONE  = 0;
   localparam int unsigned LT_KIND_LOCKA = 1;
   localparam int unsigned LT_KIND_LOCKB = 2;
   localparam int unsigned LT_KIND_TSA   = 3;
   localparam int unsigned LT_KIND_TSB   = 4;

   // kind of ordered set sent (and expected back) in each substate
   function automatic int unsigned lt_kind_of(lt_state_e s);
      case (s)
         LT_LOCK_A: return LT_KIND_LOCKA;
         LT_LOCK_B: return LT_KIND_LOCKB;
         LT_TSET_A: return LT_KIND_TSA;
         LT_TSET_B: return LT_KIND_TSB;
         default:   return LT_KIND_NONE;
      endcase
   endfunction

   function automatic logic lt_is_training(lt_state_e s);
      return (s == LT_LOCK_A) || (s == LT_LOCK_B) ||
             (s == LT_TSET_A) || (s == LT_TSET_B);
   endfunction

   function automatic lt_state_e lt_successor(lt_state_e s);
      case (s)
         LT_LOCK_A: return LT_LOCK_B;
         LT_LOCK_B: return LT_TSET_A;
         LT_TSET_A: return LT_TSET_B;
         LT_TSET_B: return LT_DONE;
         default:   return LT_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/lt_tx_tally.sv
module lt_tx_tally #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             pulse,
   input  logic [CNT_W-1:0] thr,
   output logic             reached
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lt_tx_tally: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || clr) begin
         cnt_q <= '0;
      end else if (pulse && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign reached = (cnt_q >= thr);

   AST_TX_FRESH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R8
   AST_TX_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R1

endmodule

// File: rtl/lt_rx_run.sv
module lt_rx_run #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             sym_valid,
   input  logic             sym_match,
   input  logic [CNT_W-1:0] thr,
   output logic             met
);
   localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lt_rx_run: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;
   logic             met_q;

   always_comb begin
      run_inc = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         met_q <= 1'b0;
      end else if (!en || clr) begin
         run_q <= '0;
         met_q <= 1'b0;
      end else if (sym_valid) begin
         if (sym_match) begin
            run_q <= run_inc;
            if (run_inc >= thr) met_q <= 1'b1;
         end else begin
            run_q <= '0;
         end
      end
   end

   assign met = met_q || (thr == '0);

   AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && sym_valid && !sym_match) |=> (run_q == '0)); // R5
   AST_RUN_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && !sym_valid) |=> $stable(run_q)); // R5
   AST_MET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (met_q && en && !clr) |=> met_q); // R3

endmodule

// File: rtl/lt_timer.sv
module lt_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   localparam logic [TMO_W-1:0] TMR_MAX = {TMO_W{1'b1}};

   generate
      if (TMO_W < 2) begin : g_bad_width
         $error("lt_timer: TMO_W must be at least 2");
      end
   endgenerate

   logic [TMO_W-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (!en || clr) begin
         tmr_q <= '0;
      end else if (tmr_q != TMR_MAX) begin
         tmr_q <= tmr_q + 1'b1;
      end
   end

   assign expired = en && (tmr_q >= limit);

   AST_TIMER_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (tmr_q == '0)); // R8
   AST_TIMER_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && tmr_q != TMR_MAX) |=> (tmr_q == $past(tmr_q) + 1'b1)); // R6

endmodule

// File: rtl/lt_interlock_fsm.sv
module lt_interlock_fsm
   import lt_pkg::*;
#(
   parameter int unsigned KIND_W    = 3,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned TMO_W     = 16,
   parameter int unsigned LOCK_TX   = 4,
   parameter int unsigned LOCK_RX   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              tx_set_done,
   input  logic              rx_valid,
   input  logic [KIND_W-1:0] rx_kind,
   input  logic [TMO_W-1:0]  timeout_cycles,
   input  logic [CNT_W-1:0]  ts_a_tx_thr,
   input  logic [CNT_W-1:0]  ts_a_rx_thr,
   input  logic [CNT_W-1:0]  ts_b_tx_thr,
   input  logic [CNT_W-1:0]  ts_b_rx_thr,
   output logic [2:0]        substate,
   output logic [KIND_W-1:0] send_kind,
   output logic              trained,
   output logic              retry
);
   localparam logic [CNT_W-1:0] LOCK_TX_C = CNT_W'(LOCK_TX);
   localparam logic [CNT_W-1:0] LOCK_RX_C = CNT_W'(LOCK_RX);

   generate
      if (KIND_W < 3) begin : g_bad_kind
         $error("lt_interlock_fsm: KIND_W must hold kind codes up to 4");
      end
      if (LOCK_TX >= (1 << CNT_W) || LOCK_RX >= (1 << CNT_W)) begin : g_bad_lock
         $error("lt_interlock_fsm: lock limits do not fit CNT_W");
      end
      if (LOCK_TX == 0 || LOCK_RX == 0) begin : g_bad_zero
         $error("lt_interlock_fsm: lock limits must be non-zero");
      end
   endgenerate

   lt_state_e        state_q;
   logic             trained_q;
   logic             retry_q;
   logic             in_train;
   logic [CNT_W-1:0] tx_thr;
   logic [CNT_W-1:0] rx_thr;
   logic             rx_match;
   logic             tx_ok;
   logic             rx_ok;
   logic             tmo_hit;
   logic             adv;
   logic             tmo_fire;
   logic             clr_all;

   assign in_train = lt_is_training(state_q);

   always_comb begin
      case (state_q)
         LT_TSET_A: begin tx_thr = ts_a_tx_thr; rx_thr = ts_a_rx_thr; end
         LT_TSET_B: begin tx_thr = ts_b_tx_thr; rx_thr = ts_b_rx_thr; end
         default:   begin tx_thr = LOCK_TX_C;   rx_thr = LOCK_RX_C;   end
      endcase
   end

   assign rx_match = (rx_kind == KIND_W'(lt_kind_of(state_q)));
   assign adv      = in_train && tx_ok && rx_ok;
   assign tmo_fire = in_train && tmo_hit && !adv;
   assign clr_all  = start_req || adv || tmo_fire;

   lt_tx_tally #(.CNT_W(CNT_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (in_train),
      .clr     (clr_all),
      .pulse   (tx_set_done),
      .thr     (tx_thr),
      .reached (tx_ok)
   );

   lt_rx_run #(.CNT_W(CNT_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (in_train),
      .clr       (clr_all),
      .sym_valid (rx_valid),
      .sym_match (rx_match),
      .thr       (rx_thr),
      .met       (rx_ok)
   );

   lt_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (in_train),
      .clr     (clr_all),
      .limit   (timeout_cycles),
      .expired (tmo_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= LT_IDLE;
         trained_q <= 1'b0;
         retry_q   <= 1'b0;
      end else if (start_req) begin
         state_q   <= LT_LOCK_A;
         trained_q <= 1'b0;
         retry_q   <= 1'b0;
      end else if (adv) begin
         state_q   <= lt_successor(state_q);
         if (state_q == LT_TSET_B) trained_q <= 1'b1;
         retry_q   <= 1'b0;
      end else if (tmo_fire) begin
         state_q   <= LT_LOCK_A;
         retry_q   <= 1'b1;
      end else begin
         retry_q   <= 1'b0;
      end
   end

   assign substate  = state_q;
   assign send_kind = KIND_W'(lt_kind_of(state_q));
   assign trained   = trained_q;
   assign retry     = retry_q;

   AST_ADV_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_train && !start_req && !(tx_ok && rx_ok))
      |=> (state_q == $past(state_q) || state_q == LT_LOCK_A)); // R1
   AST_STALL_KEEPS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_train && tx_ok && !rx_ok && !start_req && !tmo_hit) |=> $stable(send_kind)); // R4
   AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (retry && timeout_cycles != '0) |=> !retry); // R6
   AST_RETRY_AT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> (substate == 3'd1)); // R6
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |=> (substate == 3'd1 && !trained)); // R7
   AST_TRAINED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trained && !start_req) |=> trained); // R10
   AST_TRAINED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      trained |-> (substate == 3'd5)); // R10

endmodule

// File: tb/tb_lt_interlock_fsm.sv
`timescale 1ns/1ps
module tb_lt_interlock_fsm;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_req = 1'b0;
   logic        tx_set_done = 1'b0;
   logic        rx_valid = 1'b0;
   logic [2:0]  rx_kind = 3'd0;
   logic [15:0] timeout_cycles = 16'd40;
   logic [7:0]  ts_a_tx_thr = 8'd2;
   logic [7:0]  ts_a_rx_thr = 8'd3;
   logic [7:0]  ts_b_tx_thr = 8'd1;
   logic [7:0]  ts_b_rx_thr = 8'd3;
   logic [2:0]  substate;
   logic [2:0]  send_kind;
   logic        trained;
   logic        retry;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   lt_interlock_fsm dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .tx_set_done(tx_set_done),
      .rx_valid(rx_valid), .rx_kind(rx_kind), .timeout_cycles(timeout_cycles),
      .ts_a_tx_thr(ts_a_tx_thr), .ts_a_rx_thr(ts_a_rx_thr),
      .ts_b_tx_thr(ts_b_tx_thr), .ts_b_rx_thr(ts_b_rx_thr),
      .substate(substate), .send_kind(send_kind), .trained(trained), .retry(retry)
   );

   // behavioural reference model
   int m_st, m_tx, m_run, m_tmo;
   bit m_lat, m_trained, m_retry;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_tx = 0; m_run = 0; m_tmo = 0;
         m_lat = 0; m_trained = 0; m_retry = 0;
      end else begin
         int txt, rxt;
         bit intr, txok, rxok, adv, expd;
         intr = (m_st >= 1 && m_st <= 4);
         txt = (m_st == 3) ? int'(ts_a_tx_thr) : (m_st == 4) ? int'(ts_b_tx_thr) : 4;
         rxt = (m_st == 3) ? int'(ts_a_rx_thr) : (m_st == 4) ? int'(ts_b_rx_thr) : 2;
         txok = (m_tx >= txt);
         rxok = m_lat || (rxt == 0);
         adv  = intr && txok && rxok;
         expd = intr && (m_tmo >= int'(timeout_cycles)) && !adv;
         if (start_req) begin
            m_st = 1; m_trained = 0; m_retry = 0;
            m_tx = 0; m_run = 0; m_lat = 0; m_tmo = 0;
         end else if (adv) begin
            if (m_st == 4) begin m_st = 5; m_trained = 1; end
            else m_st = m_st + 1;
            m_retry = 0;
            m_tx = 0; m_run = 0; m_lat = 0; m_tmo = 0;
         end else if (expd) begin
            m_st = 1; m_retry = 1;
            m_tx = 0; m_run = 0; m_lat = 0; m_tmo = 0;
         end else begin
            m_retry = 0;
            if (intr) begin
               if (tx_set_done && m_tx < 255) m_tx++;
               if (rx_valid) begin
                  if (int'(rx_kind) == m_st) begin
                     if (m_run < 255) m_run++;
                     if (m_run >= rxt) m_lat = 1;
                  end else m_run = 0;
               end
               if (m_tmo < 65535) m_tmo++;
            end else begin
               m_tx = 0; m_run = 0; m_lat = 0; m_tmo = 0;
            end
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      chk("R1 substate vs model", int'(substate), m_st);
      chk("R11 send_kind vs model", int'(send_kind), (m_st >= 1 && m_st <= 4) ? m_st : 0);
      chk("R10 trained vs model", int'(trained), int'(m_trained));
      chk("R6 retry vs model", int'(retry), int'(m_retry));
   endtask

   // drive one cycle of stimulus, then compare after the edge
   task automatic tick(bit st, bit txd, bit rv, int rk);
      start_req = st; tx_set_done = txd; rx_valid = rv; rx_kind = 3'(rk);
      @(negedge clk);
      start_req = 0; tx_set_done = 0; rx_valid = 0; rx_kind = 0;
      cmp_model();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 reset substate", int'(substate), 0);
      chk("R12 reset send_kind", int'(send_kind), 0);
      chk("R12 reset trained", int'(trained), 0);
      chk("R12 reset retry", int'(retry), 0);

      // first lock substate: receive met early, transmit finishes later
      tick(1, 0, 0, 0);
      chk("R7 start enters substate 1", int'(substate), 1);
      tick(0, 0, 1, 1); tick(0, 0, 1, 1);
      tick(0, 1, 0, 0); tick(0, 1, 0, 0); tick(0, 1, 0, 0);
      chk("R2 three tx sets not enough", int'(substate), 1);
      tick(0, 1, 0, 0);
      chk("R3 latched rx waits for tx", int'(substate), 1);
      idle(1);
      chk("R2 advance to substate 2", int'(substate), 2);

      // second lock substate: transmit done, receive lagging
      for (int i = 0; i < 5; i++) tick(0, 1, 0, 0);
      idle(3);
      chk("R4 stall keeps substate", int'(substate), 2);
      chk("R4 stall keeps send_kind", int'(send_kind), 2);
      tick(0, 0, 1, 2); tick(0, 0, 1, 1); tick(0, 0, 1, 2);
      idle(1);
      chk("R5 wrong kind breaks run", int'(substate), 2);
      tick(0, 0, 1, 2);
      idle(1);
      chk("R5 gap does not break run", int'(substate), 3);

      // first training-set substate: port thresholds, nothing carried over
      tick(0, 0, 1, 3); tick(0, 0, 1, 3); tick(0, 0, 1, 3);
      idle(1);
      chk("R8 tx count fresh on entry", int'(substate), 3);
      tick(0, 1, 0, 0); tick(0, 1, 0, 0);
      chk("R1 advance waits one edge", int'(substate), 3);
      idle(1);
      chk("R9 substate 3 limits", int'(substate), 4);

      // second training-set substate
      tick(0, 1, 0, 0);
      tick(0, 0, 1, 4); tick(0, 0, 1, 4);
      idle(1);
      chk("R9 substate 4 needs three rx", int'(substate), 4);
      tick(0, 0, 1, 4);
      chk("R10 not trained yet", int'(trained), 0);
      idle(1);
      chk("R10 trained state", int'(substate), 5);
      chk("R10 trained flag", int'(trained), 1);
      idle(5);
      chk("R10 trained holds", int'(trained), 1);
      chk("R11 send_kind zero when trained", int'(send_kind), 0);

      // restart from trained and mid-substate
      tick(1, 0, 0, 0);
      chk("R7 restart substate", int'(substate), 1);
      chk("R7 restart clears trained", int'(trained), 0);
      tick(0, 0, 1, 1); tick(0, 0, 1, 1);
      tick(1, 0, 0, 0);
      for (int i = 0; i < 4; i++) tick(0, 1, 0, 0);
      idle(2);
      chk("R7 restart discards rx latch", int'(substate), 1);

      // timeout in first lock substate
      timeout_cycles = 16'd10;
      tick(1, 0, 0, 0);
      idle(10);
      chk("R6 no retry before limit", int'(retry), 0);
      idle(1);
      chk("R6 retry pulse", int'(retry), 1);
      chk("R6 retry at substate 1", int'(substate), 1);
      idle(1);
      chk("R6 retry one cycle", int'(retry), 0);

      // timeout in a later substate
      tick(0, 0, 1, 1); tick(0, 0, 1, 1);
      for (int i = 0; i < 4; i++) tick(0, 1, 0, 0);
      idle(1);
      chk("R8 timer fresh after retry", int'(substate), 2);
      idle(10);
      chk("R6 waiting in substate 2", int'(substate), 2);
      idle(1);
      chk("R6 later timeout returns", int'(substate), 1);
      chk("R6 later timeout retry", int'(retry), 1);
      chk("R11 send_kind after retry", int'(send_kind), 1);
      idle(2);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule